// File: doc/BRIEF.md
# Thermometer-Coded Delay-Line PWM Controller

This block produces the drive pulse for a low-voltage buck converter. The duty command is not a binary number. It is a thermometer code held in a bidirectional shift register: ones fill the low positions and zeros fill the rest. Each time the shift strobe is accepted, a one-bit comparator result moves the code one position. When the output is low, one more stage is switched in. When the output is high, one stage is dropped. The number of ones in the code chooses a tap on a chain of delay stages. A pulse launched on the switching strobe stays high until the launch edge reaches that tap.

All logic runs on one fast clock. The switching edge and the shift clock arrive as single-cycle strobes. Each delay stage is modelled as a fixed number of clock cycles. A pulse of n stages is therefore n × `STAGE_CYC` cycles wide. The code is never changed while a pulse is in flight. A shift strobe that arrives during a pulse is held and applied on the first idle cycle.

Top module: `tdpwm_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `pwm_out` is low. The code resets to one stage only, so the first pulse is `STAGE_CYC` cycles wide.
- R2: The code always holds a contiguous run of ones starting at bit 0. At least one stage is always selected.
- R3: An accepted shift strobe with `cmp_low`=1 adds one stage. An accepted shift strobe with `cmp_low`=0 removes one stage.
- R4: A `sw_tick` sampled while the pulse is low drives `pwm_out` high on the following cycle.
- R5: A pulse lasts n × `STAGE_CYC` clock cycles, where n is the number of ones in the code when `sw_tick` was sampled.
- R6: An up shift with all `STAGES` bits set leaves the code full, so the pulse stays `STAGES` × `STAGE_CYC` cycles wide.
- R7: A down shift with only bit 0 set leaves one stage selected.
- R8: A shift strobe sampled while `pwm_out` is high, or together with `sw_tick`, does not alter the current pulse. Its direction is stored and applied on the first cycle with neither condition.
- R9: A `sw_tick` sampled while `pwm_out` is high is ignored. The pulse neither restarts nor changes width.
- R10: A fresh shift strobe in the cycle a stored one would be applied takes effect by itself, and the stored one is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; delay stages are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_tick | input | 1 | One-cycle switching-edge strobe that launches a pulse |
| sh_tick | input | 1 | One-cycle shift-clock strobe that moves the code |
| cmp_low | input | 1 | Comparator result: 1 = output below reference, 0 = above |
| pwm_out | output | 1 | PWM drive pulse |

## Verification
The code is walked in one direction for longer than its length, so that both saturation limits are reached. An alternating up/down pattern then exposes wrong step sizes or directions. Shift strobes are placed during a pulse, together with the switching strobe, and on the exact cycle a stored shift would apply. These placements separate deferred updates from immediate ones and show which strobe wins when they collide. An extra switching strobe inside a pulse shows whether the pulse restarts or is stretched.

// File: rtl/tdpwm_pkg.sv
package tdpwm_pkg;
  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_UP   = 2'd1,
    SH_DOWN = 2'd2
  } shift_op_e;
endpackage

// File: rtl/tdpwm_therm_reg.sv
module tdpwm_therm_reg
  import tdpwm_pkg::*;
#(
  parameter int unsigned STAGES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shift_op_e         op,
  output logic [STAGES-1:0] code
);
  localparam logic [STAGES-1:0] ONE = {{(STAGES-1){1'b0}}, 1'b1};

  logic [STAGES-1:0] code_q, code_d;
  logic              code_en;

  assign code_en = (op != SH_NONE);

  always_comb begin
    unique case (op)
      SH_UP:   code_d = {code_q[STAGES-2:0], 1'b1};
      SH_DOWN: code_d = {1'b0, code_q[STAGES-1:1]} | ONE;
      default: code_d = code_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= ONE;
    else if (code_en) code_q <= code_d;
  end

  assign code = code_q;

  AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    code_q[0] && ((code_q & (code_q + ONE)) == '0)) else $error("therm shape"); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SH_UP && !code_q[STAGES-1]) |=> $countones(code_q) == $countones($past(code_q)) + 1)
    else $error("step up"); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SH_DOWN && code_q[1]) |=> $countones(code_q) + 1 == $countones($past(code_q)))
    else $error("step down"); // R3
  AST_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SH_UP && (&code_q)) |=> (&code_q)) else $error("top sat"); // R6
  AST_BOT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SH_DOWN && code_q == ONE) |=> code_q == ONE) else $error("bottom sat"); // R7
endmodule

// File: rtl/tdpwm_tap_enc.sv
module tdpwm_tap_enc #(
  parameter int unsigned STAGES = 32,
  localparam int unsigned IW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic [STAGES-1:0] code,
  output logic [IW-1:0]     idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < int'(STAGES); i++) begin
      if (code[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tdpwm_delay_line.sv
module tdpwm_delay_line #(
  parameter int unsigned STAGES    = 32,
  parameter int unsigned STAGE_CYC = 2,
  localparam int unsigned IW    = (STAGES > 1) ? $clog2(STAGES) : 1,
  localparam int unsigned DEPTH = STAGES * STAGE_CYC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [IW-1:0] sel,
  output logic          hit
);
  logic [DEPTH-1:0]  chain_q, chain_d;
  logic [STAGES-1:0] tap;

  always_comb begin
    chain_d    = launch ? '0 : (chain_q << 1);
    chain_d[0] = launch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  for (genvar t = 0; t < STAGES; t++) begin : g_tap
    assign tap[t] = chain_q[(t+1)*STAGE_CYC-1];
  end

  assign hit = tap[sel];
endmodule

// File: rtl/tdpwm_ctrl.sv
module tdpwm_ctrl
  import tdpwm_pkg::*;
#(
  parameter int unsigned STAGES    = 32,
  parameter int unsigned STAGE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_tick,
  input  logic sh_tick,
  input  logic cmp_low,
  output logic pwm_out
);
  localparam int unsigned IW = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic [1:0]        rsync_q;
  logic              rst_core_n;
  logic [STAGES-1:0] code;
  logic [IW-1:0]     idx, sel_q;
  logic              pwm_q, pwm_d, hit, busy, launch;
  logic              pend_q, pend_d, pend_dir_q, pend_dir_d;
  shift_op_e         op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign busy   = pwm_q | sw_tick;
  assign launch = sw_tick & ~pwm_q;

  always_comb begin
    op         = SH_NONE;
    pend_d     = pend_q;
    pend_dir_d = pend_dir_q;
    if (sh_tick) begin
      if (busy) begin
        pend_d     = 1'b1;
        pend_dir_d = cmp_low;
      end else begin
        op     = cmp_low ? SH_UP : SH_DOWN;
        pend_d = 1'b0;
      end
    end else if (pend_q && !busy) begin
      op     = pend_dir_q ? SH_UP : SH_DOWN;
      pend_d = 1'b0;
    end
  end

  always_comb begin
    pwm_d = pwm_q;
    if (launch)           pwm_d = 1'b1;
    else if (pwm_q & hit) pwm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pwm_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_dir_q <= 1'b0;
    end else begin
      pwm_q      <= pwm_d;
      pend_q     <= pend_d;
      pend_dir_q <= pend_dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  sel_q <= '0;
    else if (launch)  sel_q <= idx;
  end

  tdpwm_therm_reg #(.STAGES(STAGES)) u_code (
    .clk(clk), .rst_n(rst_core_n), .op(op), .code(code));

  tdpwm_tap_enc #(.STAGES(STAGES)) u_enc (
    .code(code), .idx(idx));

  tdpwm_delay_line #(.STAGES(STAGES), .STAGE_CYC(STAGE_CYC)) u_line (
    .clk(clk), .rst_n(rst_core_n), .launch(launch), .sel(sel_q), .hit(hit));

  assign pwm_out = pwm_q;

  logic [31:0] wcnt_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)        wcnt_q <= '0;
    else if (launch)        wcnt_q <= 32'd1;
    else if (pwm_q && pwm_d) wcnt_q <= wcnt_q + 32'd1;
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_core_n)
    launch |=> pwm_q) else $error("pulse start"); // R4
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(pwm_q) |-> wcnt_q == (32'(sel_q) + 32'd1) * STAGE_CYC) else $error("pulse width"); // R5
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy |=> $stable(code)) else $error("code moved in pulse"); // R8
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_core_n)
    pwm_q |=> $stable(sel_q)) else $error("retrigger"); // R9
endmodule

// File: tb/sim_tdpwm_ctrl.sv
module sim_tdpwm_ctrl;
  localparam int STAGES = 32;
  localparam int C      = 2;
  localparam int P      = 80;

  logic clk = 1'b0;
  logic rst_n, sw_tick, sh_tick, cmp_low;
  logic pwm_out;

  always #10 clk = ~clk;

  tdpwm_ctrl #(.STAGES(STAGES), .STAGE_CYC(C)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick), .sh_tick(sh_tick),
    .cmp_low(cmp_low), .pwm_out(pwm_out));

  int checks = 0, errors = 0;
  string phase = "R1";

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int rcnt = 0, m_lvl = 1, m_cnt = 0, m_wid = 0;
  bit m_pwm = 0, m_pend = 0, m_pdir = 0, m_busy, m_launch;

  function automatic int step(int lvl, bit up);
    if (up) return (lvl < STAGES) ? lvl + 1 : lvl;
    return (lvl > 1) ? lvl - 1 : lvl;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0; else rcnt++;
      m_lvl = 1; m_pwm = 0; m_cnt = 0; m_pend = 0; m_pdir = 0;
    end else begin
      m_busy   = m_pwm || sw_tick;
      m_launch = sw_tick && !m_pwm;
      if (sh_tick) begin
        if (m_busy) begin m_pend = 1; m_pdir = cmp_low; end
        else begin m_lvl = step(m_lvl, cmp_low); m_pend = 0; end
      end else if (m_pend && !m_busy) begin
        m_lvl = step(m_lvl, m_pdir); m_pend = 0;
      end
      if (m_launch) begin m_pwm = 1; m_cnt = 1; m_wid = m_lvl * C; end
      else if (m_pwm) begin
        if (m_cnt == m_wid) m_pwm = 0; else m_cnt++;
      end
    end
  end

  int hi_run = 0, last_w = 0, pulses = 0;
  always @(negedge clk) begin
    chk(pwm_out === m_pwm, phase, int'(pwm_out), int'(m_pwm));
    if (pwm_out === 1'b1) hi_run++;
    else if (hi_run > 0) begin last_w = hi_run; hi_run = 0; pulses++; end
  end

  task automatic cyc(bit sw, bit sh, bit cmp);
    @(negedge clk);
    #1;
    sw_tick = sw; sh_tick = sh; cmp_low = cmp;
  endtask

  // one switching period; -1 disables a slot
  task automatic period(int sa, bit ca, int sb, bit cb, int xsw);
    for (int i = 0; i < P; i++) begin
      bit sh, c;
      sh = (i == sa) || (i == sb);
      c  = (i == sb) ? cb : ca;
      cyc(i == 0 || i == xsw, sh, c);
    end
  endtask

  task automatic shift_n(int n, bit up);
    for (int k = 0; k < n; k++) period(70, up, -1, 1'b0, -1);
  endtask

  initial begin
    rst_n = 1'b0; sw_tick = 1'b0; sh_tick = 1'b0; cmp_low = 1'b0;
    repeat (4) @(negedge clk);
    chk(pwm_out === 1'b0, "R1", int'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pwm_out === 1'b0, "R1", int'(pwm_out), 0);

    period(-1, 1'b0, -1, 1'b0, -1);
    chk(last_w == C, "R1", last_w, C);
    cyc(0, 0, 0);

    phase = "R3";
    shift_n(5, 1'b1);
    period(-1, 1'b0, -1, 1'b0, -1);
    chk(last_w == 6 * C, "R3", last_w, 6 * C);

    phase = "R6";
    shift_n(STAGES + 8, 1'b1);
    period(-1, 1'b0, -1, 1'b0, -1);
    chk(last_w == STAGES * C, "R6", last_w, STAGES * C);

    phase = "R3";
    shift_n(3, 1'b0);
    period(-1, 1'b0, -1, 1'b0, -1);
    chk(last_w == (STAGES - 3) * C, "R3", last_w, (STAGES - 3) * C);

    phase = "R7";
    shift_n(STAGES + 8, 1'b0);
    period(-1, 1'b0, -1, 1'b0, -1);
    chk(last_w == C, "R7", last_w, C);

    phase = "R8";
    shift_n(4, 1'b1);                       // level 5
    period(3, 1'b1, -1, 1'b0, -1);          // shift inside pulse
    chk(last_w == 5 * C, "R8", last_w, 5 * C);
    period(-1, 1'b0, -1, 1'b0, -1);
    chk(last_w == 6 * C, "R8", last_w, 6 * C);
    period(0, 1'b0, -1, 1'b0, -1);          // shift together with sw_tick
    chk(last_w == 6 * C, "R8", last_w, 6 * C);
    period(-1, 1'b0, -1, 1'b0, -1);
    chk(last_w == 5 * C, "R8", last_w, 5 * C);

    phase = "R9";
    begin
      int p0;
      p0 = pulses;
      period(-1, 1'b0, -1, 1'b0, 4);
      chk(last_w == 5 * C, "R9", last_w, 5 * C);
      chk(pulses - p0 == 1, "R9", pulses - p0, 1);
    end

    phase = "R10";
    period(2, 1'b1, 5 * C + 1, 1'b0, -1);   // stored up, fresh down on apply cycle
    period(-1, 1'b0, -1, 1'b0, -1);
    chk(last_w == 4 * C, "R10", last_w, 4 * C);

    phase = "R3";
    for (int k = 0; k < 10; k++) period(70, k[0], -1, 1'b0, -1);
    period(-1, 1'b0, -1, 1'b0, -1);
    chk(last_w == 4 * C, "R3", last_w, 4 * C);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule